// File: doc/BRIEF.md
# Packing Audio Transmit Queue

This block is the fill side of a single-channel audio transmit queue. Each cycle that `wr_en` is high, one 32-bit word is offered. The active sample width and the packing flag decide whether the word becomes one queue entry or two. Every entry is 20 bits wide. A narrower sample is moved up to the top of the entry and its low bits are filled with zeros. Because of this, the fill level counts samples and does not depend on the packing mode.

The drain side removes a left/right pair per `pop`. The two oldest entries are always visible on `rd_left` and `rd_right`. Status flags report empty, half-empty, full and underrun. A write that does not fit is dropped in full and leaves the queue untouched.

Top module: `aud_txfifo_pack`

## Requirements
- R1: After reset, `level` is 0, `empty` and `half_empty` are 1, and `full` and `underrun` are 0.
- R2: Without packing, one write stores one entry. The entry depends on `size_sel`:
  - code 3 (12-bit): `wr_data[11:0]` shifted left by 8.
  - code 0 (16-bit): `wr_data[15:0]` shifted left by 4.
  - code 1 (18-bit): `wr_data[17:0]` shifted left by 2.
  - code 2 (20-bit): `wr_data[19:0]` unshifted.
- R3: With packing active, one write stores two entries. `wr_data[15:0]` is stored first and `wr_data[31:16]` second. Each half is shifted left by 8 for code 3 and by 4 for code 0, keeping only 20 bits.
- R4: `compact_req` has no effect when `size_sel` is 1 or 2. The write then behaves as an unpacked write.
- R5: An unpacked write is accepted only while `level < DEPTH`. Otherwise it is dropped and the level and entries are unchanged.
- R6: A packed write is accepted only while `level + 2 < DEPTH`. Otherwise it is dropped and the level is unchanged.
- R7: An accepted write has these effects on the flags:
  - It clears `empty` and `underrun`.
  - It clears `half_empty` once the new level is at least DEPTH/2.
  - It sets `full` once the new level reaches DEPTH.
- R8: `pop` with `level >= 2` removes the two oldest entries. `pop` with fewer than two entries is ignored.
- R9: An accepted pop has these effects on the flags:
  - It clears `full`.
  - It sets `half_empty` when the new level is at most DEPTH/2.
  - It sets both `empty` and `underrun` when the new level is 0.
- R10: When `wr_en` and `pop` are high in the same cycle, only the write is acted on.
- R11: Entries leave in the order they were stored, including across the wrap of the storage pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Offer `wr_data` this cycle |
| wr_data | input | 32 | Sample word |
| size_sel | input | 2 | Sample width code: 0=16, 1=18, 2=20, 3=12 bits |
| compact_req | input | 1 | Request two 16-bit halves per word |
| pop | input | 1 | Remove the oldest pair |
| rd_left | output | 20 | Oldest entry |
| rd_right | output | 20 | Second oldest entry |
| level | output | $clog2(DEPTH)+1 | Entries held |
| empty | output | 1 | Queue empty flag |
| half_empty | output | 1 | Half-empty flag |
| full | output | 1 | Full flag |
| underrun | output | 1 | Drained to zero by a pop |

## Verification
One fixed word is written under every size code, both with and without the packing request. The entries that result show whether the shift amount is right for each width and whether the low half is stored ahead of the high half. They also show whether the 18-bit and 20-bit codes correctly ignore packing. Fill sequences that stop one entry short of the acceptance limit, and then exactly at it, separate the strict packed bound from the unpacked one. A sequence that fills, drains part way, refills past the pointer wrap and then drains completely confirms the pop order and every flag transition.

// File: rtl/aud_txfifo_pack.sv
module aud_txfifo_pack #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [31:0]              wr_data,
  input  logic [1:0]               size_sel,
  input  logic                     compact_req,
  input  logic                     pop,
  output logic [19:0]              rd_left,
  output logic [19:0]              rd_right,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     empty,
  output logic                     half_empty,
  output logic                     full,
  output logic                     underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW:0] DEP  = (LW+1)'(DEPTH);
  localparam logic [LW:0] HALF = (LW+1)'(DEPTH / 2);

  logic [19:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          packed_on, accept, pop_ok;
  logic [19:0]   s_lo, s_hi, s_single;
  logic [LW:0]   lvl_x, lvl_push, lvl_pop;

  assign packed_on = compact_req && (size_sel == 2'd0 || size_sel == 2'd3);
  assign lvl_x     = {1'b0, level};
  assign accept    = wr_en && (packed_on ? (lvl_x + 2 < DEP) : (lvl_x < DEP));
  assign pop_ok    = pop && !wr_en && (lvl_x >= 2);
  assign lvl_push  = lvl_x + (packed_on ? 2 : 1);
  assign lvl_pop   = lvl_x - 2;

  always_comb begin
    case (size_sel)
      2'd0:    s_single = {wr_data[15:0], 4'h0};
      2'd1:    s_single = {wr_data[17:0], 2'b00};
      2'd2:    s_single = wr_data[19:0];
      default: s_single = {wr_data[11:0], 8'h00};
    endcase
    if (size_sel == 2'd3) begin
      s_lo = {wr_data[11:0], 8'h00};
      s_hi = {wr_data[27:16], 8'h00};
    end else begin
      s_lo = {wr_data[15:0], 4'h0};
      s_hi = {wr_data[31:16], 4'h0};
    end
  end

  assign rd_left  = mem[rd_ptr];
  assign rd_right = mem[rd_ptr + 1'b1];

  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wr_ptr] <= packed_on ? s_lo : s_single;
      if (packed_on) mem[wr_ptr + 1'b1] <= s_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      level      <= '0;
      empty      <= 1'b1;
      half_empty <= 1'b1;
      full       <= 1'b0;
      underrun   <= 1'b0;
    end else if (accept) begin
      wr_ptr   <= wr_ptr + (packed_on ? AW'(2) : AW'(1));
      level    <= lvl_push[LW-1:0];
      empty    <= 1'b0;
      underrun <= 1'b0;
      if (lvl_push >= HALF) half_empty <= 1'b0;
      if (lvl_push >= DEP)  full <= 1'b1;
    end else if (pop_ok) begin
      rd_ptr <= rd_ptr + AW'(2);
      level  <= lvl_pop[LW-1:0];
      full   <= 1'b0;
      if (lvl_pop <= HALF) half_empty <= 1'b1;
      if (lvl_pop == 0) begin
        empty    <= 1'b1;
        underrun <= 1'b1;
      end
    end
  end
endmodule

module aud_txfifo_pack_chk #(
  parameter int DEPTH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   pop,
  input logic                   compact_req,
  input logic [1:0]             size_sel,
  input logic [$clog2(DEPTH):0] level,
  input logic                   full,
  input logic                   empty
);
  logic pk;
  assign pk = compact_req && (size_sel == 2'd0 || size_sel == 2'd3);

  // R5
  nc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !pk && (level == DEPTH) |=> $stable(level));
  // R6
  cm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && pk && (level + 2 >= DEPTH) |=> $stable(level));
  // R8
  pop_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !wr_en && (level >= 2) |=> (level + 2 == $past(level)));
  // R10
  wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && pop |=> (level >= $past(level)));
  // R7
  full_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (level == DEPTH));
  // R9
  empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (level == 0));
endmodule

bind aud_txfifo_pack aud_txfifo_pack_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pop(pop),
  .compact_req(compact_req), .size_sel(size_sel), .level(level),
  .full(full), .empty(empty)
);

// File: tb/aud_txfifo_pack_tb.sv
`timescale 1ns/1ps
module aud_txfifo_pack_tb;
  localparam int DEPTH = 8;
  logic clk = 1'b0;
  logic rst_n, wr_en, compact_req, pop;
  logic [31:0] wr_data;
  logic [1:0]  size_sel;
  logic [19:0] rd_left, rd_right;
  logic [3:0]  level;
  logic empty, half_empty, full, underrun;
  int runs = 0, fails = 0;

  always #2.5 clk = ~clk;

  aud_txfifo_pack #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .size_sel(size_sel), .compact_req(compact_req), .pop(pop),
    .rd_left(rd_left), .rd_right(rd_right), .level(level), .empty(empty),
    .half_empty(half_empty), .full(full), .underrun(underrun));

  // {size, compact, data, first entry, second entry, entry count}
  localparam logic [76:0] VEC [8] = '{
    {2'd0, 1'b0, 32'h98765ABC, 20'h5ABC0, 20'h00000, 2'd1},
    {2'd1, 1'b0, 32'h98765ABC, 20'h96AF0, 20'h00000, 2'd1},
    {2'd2, 1'b0, 32'h98765ABC, 20'h65ABC, 20'h00000, 2'd1},
    {2'd3, 1'b0, 32'h98765ABC, 20'hABC00, 20'h00000, 2'd1},
    {2'd0, 1'b1, 32'h98765ABC, 20'h5ABC0, 20'h98760, 2'd2},
    {2'd3, 1'b1, 32'h98765ABC, 20'hABC00, 20'h87600, 2'd2},
    {2'd1, 1'b1, 32'h98765ABC, 20'h96AF0, 20'h00000, 2'd1},
    {2'd2, 1'b1, 32'h98765ABC, 20'h65ABC, 20'h00000, 2'd1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; pop = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] sz, input logic cm, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; size_sel = sz; compact_req = cm; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; pop = 1'b0; compact_req = 1'b0;
    size_sel = 2'd0; wr_data = '0;
    do_reset();
    // R1
    chk("R1 level", level, 0);
    chk("R1 empty", empty, 1);
    chk("R1 half_empty", half_empty, 1);
    chk("R1 full", full, 0);
    chk("R1 underrun", underrun, 0);

    // R2 R3 R4 vector table
    for (int i = 0; i < 8; i++) begin
      do_reset();
      wr(VEC[i][76:75], VEC[i][74], VEC[i][73:42]);
      chk("R2/R3/R4 level", level, int'(VEC[i][1:0]));
      chk("R2/R3 first entry", rd_left, int'(VEC[i][41:22]));
      if (VEC[i][1:0] == 2'd2) chk("R3 second entry", rd_right, int'(VEC[i][21:2]));
    end

    // R5 R7 fill unpacked
    do_reset();
    for (int i = 1; i <= DEPTH; i++) begin
      wr(2'd2, 1'b0, i);
      if (i == 1) begin
        chk("R7 empty cleared", empty, 0);
        chk("R7 underrun low", underrun, 0);
      end
      if (i == 3) chk("R7 half_empty kept", half_empty, 1);
      if (i == 4) chk("R7 half_empty cleared", half_empty, 0);
      if (i == 7) chk("R7 not full", full, 0);
    end
    chk("R7 full", full, 1);
    wr(2'd2, 1'b0, 32'hFFFFF);
    chk("R5 dropped level", level, DEPTH);
    chk("R5 head unchanged", rd_left, 1);

    // R8 R9 drain
    do_pop();
    chk("R8 level after pop", level, 6);
    chk("R9 full cleared", full, 0);
    chk("R9 half_empty still low", half_empty, 0);
    chk("R8 head", rd_left, 3);
    do_pop();
    chk("R9 half_empty set", half_empty, 1);
    do_pop();
    chk("R9 not empty", empty, 0);
    do_pop();
    chk("R9 empty", empty, 1);
    chk("R9 underrun", underrun, 1);
    do_pop();
    chk("R8 ignored pop", level, 0);
    wr(2'd2, 1'b0, 5);
    chk("R7 underrun cleared", underrun, 0);
    do_pop();
    chk("R8 pop with one entry ignored", level, 1);

    // R6 packed bound
    do_reset();
    for (int i = 0; i < 5; i++) wr(2'd2, 1'b0, i);
    wr(2'd0, 1'b1, 32'h11112222);
    chk("R6 accepted at 5", level, 7);
    do_reset();
    for (int i = 0; i < 6; i++) wr(2'd2, 1'b0, i);
    wr(2'd0, 1'b1, 32'h11112222);
    chk("R6 dropped at 6", level, 6);
    chk("R6 full stays low", full, 0);

    // R10 priority
    do_reset();
    for (int i = 0; i < 4; i++) wr(2'd2, 1'b0, i);
    @(negedge clk); wr_en = 1'b1; pop = 1'b1; wr_data = 32'h9;
    @(negedge clk); wr_en = 1'b0; pop = 1'b0;
    chk("R10 write wins", level, 5);
    chk("R10 head kept", rd_left, 0);

    // R11 wrap order
    do_reset();
    for (int i = 0; i < DEPTH; i++) wr(2'd2, 1'b0, i);
    do_pop();
    wr(2'd2, 1'b0, 32'h100);
    wr(2'd2, 1'b0, 32'h101);
    for (int p = 0; p < 4; p++) begin
      chk("R11 left", rd_left, (p < 3) ? 2 + 2*p : 32'h100);
      chk("R11 right", rd_right, (p < 3) ? 3 + 2*p : 32'h101);
      do_pop();
    end
    chk("R11 drained", level, 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule